// File: doc/BRIEF.md
# Logic Analyzer Trigger Event Detector

This block sits behind the input sampler of a logic analyzer and turns each bus sample into a set of one-cycle event flags that a trigger sequencer consumes. One sample arrives every clock. From it the block works out five independent conditions: a masked pattern match over the whole bus, an inclusive range match on a numeric field of the bus, a transition of one selected channel, a pattern match that coincides with a falling edge on a strobe channel, and a strobe pulse that ended too early.

All settings arrive on plain configuration inputs that the surrounding register file holds steady. Every flag is registered and appears two clock edges after its sample was presented on `smp_i`: one edge loads the sample, the next registers the verdict. Flags that compare a sample with the one before it never fire on the first sample after reset. Sequencing, capture storage and display formatting are left to other blocks.

Top module: `trig_evt_det`

## Requirements
- R1: While reset is asserted, and for the first cycle after it is released, all five event outputs are low; a flag that depends on the previous sample never fires on the first sample after reset.
- R2: `ev_pat` is high two edges after a sample in which every bit whose `pat_care` bit is 1 equals the same bit of `pat_val`; bits whose `pat_care` bit is 0 are ignored.
- R3: `ev_rng` is high two edges after a sample whose field `smp_i[FIELD_LSB +: FIELD_W]` (bits 11..4 by default), read as unsigned, satisfies `rng_lo <= field <= rng_hi`; both bounds count as inside.
- R4: When `rng_lo` is greater than `rng_hi`, `ev_rng` never fires, whatever the field value.
- R5: `ev_edge` reports a transition of channel `edge_ch` between two consecutive samples, one cycle per transition; `edge_mode` 0 selects low-to-high, 1 high-to-low, 2 either direction, 3 disables the flag.
- R6: `ev_qual` is high only when the sample matches the pattern of R2 and, in that same sample, channel `strb_ch` is 0 while it was 1 in the previous sample.
- R7: A strobe pulse is a run of consecutive samples in which channel `strb_ch` equals `strb_act_hi` (1 = active high, 0 = active low); `ev_short` fires when such a run ends after fewer than `min_width` samples. A run of exactly `min_width` samples is not short, and `min_width` 0 never fires.
- R8: The pulse length count saturates at 2^CNT_W-1 (255 by default), so a pulse longer than that is measured as 255 and is never reported as short by wrap-around.
- R9: `ev_short` is reported once per pulse, in the cycle derived from the first inactive sample after the pulse (the trailing edge), and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | BUS_W | Bus sample, one per clock |
| pat_val | input | BUS_W | Pattern compare value |
| pat_care | input | BUS_W | Pattern mask, 1 = bit is compared |
| rng_lo | input | FIELD_W | Lower range bound, inclusive |
| rng_hi | input | FIELD_W | Upper range bound, inclusive |
| edge_ch | input | $clog2(BUS_W) | Channel watched for transitions |
| edge_mode | input | 2 | 0 rise, 1 fall, 2 any, 3 off |
| strb_ch | input | $clog2(BUS_W) | Strobe channel for qualifier and pulse check |
| strb_act_hi | input | 1 | Strobe active level |
| min_width | input | CNT_W | Shortest acceptable pulse in samples |
| ev_pat | output | 1 | Pattern match event |
| ev_rng | output | 1 | Range match event |
| ev_edge | output | 1 | Channel transition event |
| ev_qual | output | 1 | Pattern with strobe falling edge event |
| ev_short | output | 1 | Short strobe pulse event |

## Verification
The bench aims at the range bounds themselves, where a design using strict comparisons would miss the values equal to `rng_lo` or `rng_hi`, and at an inverted bound pair, where a design that swapped or ignored the order would report matches. Pulses of length `min_width - 1` and exactly `min_width` separate a less-than test from a less-or-equal one, and a 300-sample pulse against a limit of 255 exposes a counter that wraps and then calls a long pulse short. Strobe falls with and without the pattern present, plus a strobe rise with it present, catch a qualifier that ignores either half of its condition or looks at the wrong direction, and the first sample after reset catches edge logic that compares against a stale reset value.

// File: rtl/trig_evt_pkg.sv
package trig_evt_pkg;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_ANY  = 2'd2,
      EDGE_OFF  = 2'd3
   } edge_mode_e;

endpackage

// File: rtl/trig_pat_cmp.sv
// Masked pattern comparator: a bit takes part only where its care bit is set.
module trig_pat_cmp #(
   parameter int WIDTH = 16
) (
   input  logic [WIDTH-1:0] bus,
   input  logic [WIDTH-1:0] value,
   input  logic [WIDTH-1:0] care,
   output logic             hit
);

   if (WIDTH < 1) begin : g_bad_width
      $error("trig_pat_cmp: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] miss;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign miss[i] = care[i] & (bus[i] ^ value[i]);
   end

   assign hit = ~|miss;

endmodule

// File: rtl/trig_rng_cmp.sv
// Inclusive window comparator on an unsigned field.
module trig_rng_cmp #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] field,
   input  logic [WIDTH-1:0] lo,
   input  logic [WIDTH-1:0] hi,
   output logic             hit
);

   if (WIDTH < 1) begin : g_bad_width
      $error("trig_rng_cmp: WIDTH must be at least 1");
   end

   logic above_lo;
   logic below_hi;

   assign above_lo = (field >= lo);
   assign below_hi = (field <= hi);
   // an inverted window has no value satisfying both sides
   assign hit      = above_lo & below_hi;

endmodule

// File: rtl/trig_edge_sel.sv
// Per-channel transition detector with channel and direction select.
module trig_edge_sel
   import trig_evt_pkg::*;
#(
   parameter int N = 16
) (
   input  logic [N-1:0]         cur,
   input  logic [N-1:0]         prev,
   input  logic                 pair_vld,
   input  logic [$clog2(N)-1:0] ch,
   input  logic [1:0]           mode,
   output logic                 hit
);

   if (N < 2) begin : g_bad_n
      $error("trig_edge_sel: N must be at least 2");
   end

   logic [N-1:0] rise_v;
   logic [N-1:0] fall_v;

   for (genvar i = 0; i < N; i++) begin : g_chan
      assign rise_v[i] =  cur[i] & ~prev[i];
      assign fall_v[i] = ~cur[i] &  prev[i];
   end

   always_comb begin
      case (edge_mode_e'(mode))
         EDGE_RISE: hit = pair_vld & rise_v[ch];
         EDGE_FALL: hit = pair_vld & fall_v[ch];
         EDGE_ANY:  hit = pair_vld & (rise_v[ch] | fall_v[ch]);
         default:   hit = 1'b0;
      endcase
   end

endmodule

// File: rtl/trig_pulse_width.sv
// Measures runs of active strobe samples and flags runs that end too soon.
module trig_pulse_width #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act_cur,
   input  logic             act_prev,
   input  logic [CNT_W-1:0] min_width,
   output logic             short_o
);

   if (CNT_W < 2) begin : g_bad_cnt
      $error("trig_pulse_width: CNT_W must be at least 2");
   end

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic [CNT_W-1:0] run_len;
   logic             trail;

   // trailing edge: the run ended with the previous sample
   assign trail = act_prev & ~act_cur;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_len <= '0;
         short_o <= 1'b0;
      end else begin
         short_o <= trail & (run_len < min_width);
         if (!act_cur) begin
            run_len <= '0;
         end else if (!act_prev) begin
            run_len <= CNT_ONE;
         end else if (run_len != CNT_MAX) begin
            run_len <= run_len + CNT_ONE;
         end
      end
   end

   // R8: a full count stays full while the pulse goes on
   p_count_saturates_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (run_len == CNT_MAX && act_cur && act_prev) |=> (run_len == CNT_MAX))
      else $error("R8: pulse length count left saturation during a pulse");

   // R9: one report per pulse, never back to back
   p_short_single_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      short_o |=> !short_o)
      else $error("R9: short pulse reported in consecutive cycles");

   // R9: a report only follows a trailing edge
   p_short_at_trail_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      short_o |-> $past(act_prev && !act_cur))
      else $error("R9: short pulse reported away from a trailing edge");

endmodule

// File: rtl/trig_evt_det.sv
// Trigger event detector: registers the bus sample, compares it with the
// previous one and with the programmed conditions, and registers five flags.
module trig_evt_det
   import trig_evt_pkg::*;
#(
   parameter int BUS_W     = 16,
   parameter int FIELD_LSB = 4,
   parameter int FIELD_W   = 8,
   parameter int CNT_W     = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [BUS_W-1:0]         smp_i,
   input  logic [BUS_W-1:0]         pat_val,
   input  logic [BUS_W-1:0]         pat_care,
   input  logic [FIELD_W-1:0]       rng_lo,
   input  logic [FIELD_W-1:0]       rng_hi,
   input  logic [$clog2(BUS_W)-1:0] edge_ch,
   input  logic [1:0]               edge_mode,
   input  logic [$clog2(BUS_W)-1:0] strb_ch,
   input  logic                     strb_act_hi,
   input  logic [CNT_W-1:0]         min_width,
   output logic                     ev_pat,
   output logic                     ev_rng,
   output logic                     ev_edge,
   output logic                     ev_qual,
   output logic                     ev_short
);

   localparam int FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   if (BUS_W < 2) begin : g_bad_bus
      $error("trig_evt_det: BUS_W must be at least 2");
   end
   if (FIELD_W < 1 || FIELD_LSB < 0 || FIELD_MSB >= BUS_W) begin : g_bad_field
      $error("trig_evt_det: range field does not fit the bus");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("trig_evt_det: CNT_W must be at least 2");
   end

   // sample pipeline with validity tracking
   logic [BUS_W-1:0] cur_q;
   logic [BUS_W-1:0] prev_q;
   logic             cur_vld;
   logic             prev_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q    <= '0;
         prev_q   <= '0;
         cur_vld  <= 1'b0;
         prev_vld <= 1'b0;
      end else begin
         cur_q    <= smp_i;
         prev_q   <= cur_q;
         cur_vld  <= 1'b1;
         prev_vld <= cur_vld;
      end
   end

   logic pair_vld;
   assign pair_vld = cur_vld & prev_vld;

   // condition evaluators
   logic pat_hit;
   logic rng_hit;
   logic chan_edge;
   logic strb_fall;
   logic act_cur;
   logic act_prev;

   trig_pat_cmp #(.WIDTH(BUS_W)) u_pat (
      .bus   (cur_q),
      .value (pat_val),
      .care  (pat_care),
      .hit   (pat_hit)
   );

   trig_rng_cmp #(.WIDTH(FIELD_W)) u_rng (
      .field (cur_q[FIELD_LSB +: FIELD_W]),
      .lo    (rng_lo),
      .hi    (rng_hi),
      .hit   (rng_hit)
   );

   trig_edge_sel #(.N(BUS_W)) u_edge (
      .cur      (cur_q),
      .prev     (prev_q),
      .pair_vld (pair_vld),
      .ch       (edge_ch),
      .mode     (edge_mode),
      .hit      (chan_edge)
   );

   trig_edge_sel #(.N(BUS_W)) u_strb (
      .cur      (cur_q),
      .prev     (prev_q),
      .pair_vld (pair_vld),
      .ch       (strb_ch),
      .mode     (EDGE_FALL),
      .hit      (strb_fall)
   );

   assign act_cur  = cur_vld  & (cur_q[strb_ch]  == strb_act_hi);
   assign act_prev = prev_vld & (prev_q[strb_ch] == strb_act_hi);

   trig_pulse_width #(.CNT_W(CNT_W)) u_pw (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_cur   (act_cur),
      .act_prev  (act_prev),
      .min_width (min_width),
      .short_o   (ev_short)
   );

   // registered flags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ev_pat  <= 1'b0;
         ev_rng  <= 1'b0;
         ev_edge <= 1'b0;
         ev_qual <= 1'b0;
      end else begin
         ev_pat  <= cur_vld & pat_hit;
         ev_rng  <= cur_vld & rng_hit;
         ev_edge <= chan_edge;
         ev_qual <= cur_vld & pat_hit & strb_fall;
      end
   end

   // R1: no flag can follow a cycle without a loaded sample
   p_quiet_after_reset_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      !cur_vld |=> !(ev_pat || ev_rng || ev_edge || ev_qual || ev_short))
      else $error("R1: event flag raised without a loaded sample");

   // R4: a range event implies the window was ordered
   p_rng_ordered_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_rng |-> ($past(rng_lo) <= $past(rng_hi)))
      else $error("R4: range event with an inverted window");

   // R6: the qualified event never appears without the pattern event
   p_qual_has_pat_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      ev_qual |-> ev_pat)
      else $error("R6: qualified event without pattern match");

   // R5: a rising edge cannot be followed by another on the same channel
   p_rise_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (ev_edge && edge_mode == 2'd0) |=>
         (!ev_edge || edge_mode != 2'd0 || !$stable(edge_ch)))
      else $error("R5: rising edge reported twice in a row");

endmodule

// File: tb/tb_trig_evt_det.sv
`timescale 1ns/1ps
module tb_trig_evt_det;

   localparam int BW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [BW-1:0] smp_i = '0;
   logic [BW-1:0] pat_val = '0;
   logic [BW-1:0] pat_care = '0;
   logic [7:0]    rng_lo = '0;
   logic [7:0]    rng_hi = '0;
   logic [3:0]    edge_ch = '0;
   logic [1:0]    edge_mode = '0;
   logic [3:0]    strb_ch = '0;
   logic          strb_act_hi = 1'b1;
   logic [7:0]    min_width = '0;
   logic          ev_pat, ev_rng, ev_edge, ev_qual, ev_short;

   always #2.5 clk = ~clk;

   trig_evt_det dut (
      .clk(clk), .rst_n(rst_n), .smp_i(smp_i),
      .pat_val(pat_val), .pat_care(pat_care),
      .rng_lo(rng_lo), .rng_hi(rng_hi),
      .edge_ch(edge_ch), .edge_mode(edge_mode),
      .strb_ch(strb_ch), .strb_act_hi(strb_act_hi), .min_width(min_width),
      .ev_pat(ev_pat), .ev_rng(ev_rng), .ev_edge(ev_edge),
      .ev_qual(ev_qual), .ev_short(ev_short)
   );

   // pending configuration, applied by the driver at a negedge
   logic [BW-1:0] c_val = '0, c_care = '0;
   logic [7:0]    c_lo = 8'h10, c_hi = 8'h20, c_minw = 8'd4;
   logic [3:0]    c_ech = 4'd3, c_sch = 4'd15;
   logic [1:0]    c_mode = 2'd0;
   logic          c_act = 1'b1;
   bit            cfg_dirty = 1'b1;

   typedef struct {
      int tag;
      bit chk;
      bit pat, rng, edg, qual, shrt;
   } exp_t;

   exp_t          sb[$];
   int            cyc = 0;
   int            n_chk = 0, n_bad = 0;
   int            short_seen = 0, rng_seen = 0;
   bit            done = 1'b0;

   // reference state
   logic [BW-1:0] m_prev = '0;
   bit            m_pvld = 1'b0;
   int            m_run = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic set_cfg();
      cfg_dirty = 1'b1;
   endtask

   // driver: present one sample and push its expected verdict
   task automatic drive(input logic [BW-1:0] s);
      exp_t e;
      bit   ac, ap;
      logic [7:0] f;
      @(negedge clk);
      if (!rst_n) rst_n = 1'b1;
      if (cfg_dirty) begin
         pat_val = c_val; pat_care = c_care; rng_lo = c_lo; rng_hi = c_hi;
         edge_ch = c_ech; edge_mode = c_mode; strb_ch = c_sch;
         strb_act_hi = c_act; min_width = c_minw;
         if (sb.size() > 0) sb[sb.size()-1].chk = 1'b0;
         cfg_dirty = 1'b0;
      end
      smp_i = s;
      e.tag = cyc;
      e.chk = 1'b1;
      e.pat = (((s ^ c_val) & c_care) == '0);
      f = s[11:4];
      e.rng = (f >= c_lo) && (f <= c_hi);
      case (c_mode)
         2'd0: e.edg = m_pvld && s[c_ech] && !m_prev[c_ech];
         2'd1: e.edg = m_pvld && !s[c_ech] && m_prev[c_ech];
         2'd2: e.edg = m_pvld && (s[c_ech] != m_prev[c_ech]);
         default: e.edg = 1'b0;
      endcase
      e.qual = e.pat && m_pvld && m_prev[c_sch] && !s[c_sch];
      ac = (s[c_sch] == c_act);
      ap = m_pvld && (m_prev[c_sch] == c_act);
      e.shrt = ap && !ac && (m_run < int'(c_minw));
      if (!ac) m_run = 0;
      else if (!ap) m_run = 1;
      else if (m_run < 255) m_run = m_run + 1;
      m_prev = s;
      m_pvld = 1'b1;
      sb.push_back(e);
   endtask

   task automatic idle(input int n, input logic [BW-1:0] s);
      for (int i = 0; i < n; i++) drive(s);
   endtask

   task automatic flush();
      while (sb.size() > 0) @(negedge clk);
   endtask

   task automatic check_cnt(input string req, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic cmp1(input string req, input logic a, input bit x, input int tag);
      if (a !== x) begin
         n_bad++;
         $display("FAIL %s tag=%0d actual=%b expected=%b", req, tag, a, x);
      end
   endtask

   // monitor: pops the item whose verdict is due and compares
   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_short) short_seen++;
         if (ev_rng)   rng_seen++;
      end
      if (sb.size() > 0 && sb[0].tag + 2 == cyc) begin
         exp_t e;
         e = sb.pop_front();
         if (e.chk) begin
            n_chk++;
            cmp1("R2 ev_pat",   ev_pat,   e.pat,  e.tag);
            cmp1("R3 ev_rng",   ev_rng,   e.rng,  e.tag);
            cmp1("R5 ev_edge",  ev_edge,  e.edg,  e.tag);
            cmp1("R6 ev_qual",  ev_qual,  e.qual, e.tag);
            cmp1("R7 ev_short", ev_short, e.shrt, e.tag);
         end
      end
   end

   // pulse of given length on bit 15 from an inactive background
   task automatic pulse15(input int len, input bit hi_act);
      logic [BW-1:0] on, off;
      on  = hi_act ? 16'h8000 : 16'h0000;
      off = hi_act ? 16'h0000 : 16'h8000;
      idle(len, on);
      idle(3, off);
   endtask

   initial begin
      int s0, r0;
      // R1: outputs low during reset
      repeat (4) @(negedge clk);
      check_cnt("R1 flags during reset",
                int'(ev_pat) + int'(ev_rng) + int'(ev_edge) + int'(ev_qual) + int'(ev_short), 0);
      // first sample after reset has channel 3 high: no edge may be seen (R1)
      c_care = '0; c_val = '0; c_mode = 2'd0; set_cfg();
      drive(16'h0008);
      @(posedge clk); #1;
      check_cnt("R1 flags one cycle after release",
                int'(ev_pat) + int'(ev_rng) + int'(ev_edge) + int'(ev_qual) + int'(ev_short), 0);
      idle(4, 16'h0008);
      flush();

      // R2: masked pattern
      c_care = 16'h0FF0; c_val = 16'h0A50; set_cfg();
      idle(2, 16'h0000);
      drive(16'h0A50); drive(16'hFA5F); drive(16'h0A51); drive(16'h0B50);
      drive(16'h0A40); drive(16'h0A50);
      idle(2, 16'h0000);

      // R3: inclusive bounds 0x10..0x20 on bits 11..4
      c_lo = 8'h10; c_hi = 8'h20; set_cfg();
      idle(2, 16'h0000);
      drive(16'h00F0); drive(16'h0100); drive(16'h0180); drive(16'h0200);
      drive(16'h0210); drive(16'h0FF0);
      idle(2, 16'h0000);
      flush();

      // R4: inverted window, full sweep of the field
      c_lo = 8'h30; c_hi = 8'h20; set_cfg();
      idle(3, 16'h0000);
      flush();
      r0 = rng_seen;
      for (int v = 0; v < 256; v++) drive(16'(v << 4));
      idle(3, 16'h0000);
      flush();
      check_cnt("R4 inverted window events", rng_seen - r0, 0);
      c_lo = 8'h10; c_hi = 8'h20; set_cfg();

      // R5: edge modes on channel 3
      for (int m = 0; m < 4; m++) begin
         c_mode = 2'(m); set_cfg();
         idle(2, 16'h0000);
         drive(16'h0008); drive(16'h0008); drive(16'h0000);
         drive(16'h0008); drive(16'h0000); drive(16'h0004);
         idle(2, 16'h0000);
      end
      c_ech = 4'd0; c_mode = 2'd2; set_cfg();
      idle(2, 16'h0000);
      drive(16'h0001); drive(16'h0008); drive(16'h0000);
      idle(2, 16'h0000);

      // R6: pattern 0x5A in the low byte with strobe bit 15 falling
      c_care = 16'h00FF; c_val = 16'h005A; c_minw = 8'd0; set_cfg();
      idle(2, 16'h0000);
      drive(16'h8000); drive(16'h005A);          // fall with pattern
      drive(16'h805A); drive(16'h0011);          // fall without pattern
      drive(16'h005A); drive(16'h805A);          // rise with pattern
      drive(16'h805A); drive(16'h005A);          // fall with pattern again
      idle(3, 16'h0000);
      flush();

      // R7: active-high pulses against min_width 4; min_width 0 silent
      c_care = '0; c_minw = 8'd0; set_cfg();
      idle(3, 16'h0000);
      flush();
      s0 = short_seen;
      pulse15(1, 1'b1);
      flush();
      check_cnt("R7 min_width 0 never short", short_seen - s0, 0);
      c_minw = 8'd4; set_cfg();
      idle(3, 16'h0000);
      flush();
      s0 = short_seen;
      pulse15(4, 1'b1);
      pulse15(6, 1'b1);
      flush();
      check_cnt("R7 pulses of 4 and 6 not short", short_seen - s0, 0);
      s0 = short_seen;
      pulse15(3, 1'b1);
      flush();
      check_cnt("R9 one report for a 3-sample pulse", short_seen - s0, 1);
      s0 = short_seen;
      pulse15(1, 1'b1);
      pulse15(2, 1'b1);
      flush();
      check_cnt("R7 pulses of 1 and 2 short", short_seen - s0, 2);

      // R7: active-low strobe, idle level high
      idle(2, 16'h8000);
      c_act = 1'b0; set_cfg();
      idle(4, 16'h8000);
      flush();
      s0 = short_seen;
      pulse15(2, 1'b0);
      pulse15(5, 1'b0);
      flush();
      check_cnt("R7 active-low pulses", short_seen - s0, 1);
      c_act = 1'b1; set_cfg();
      idle(4, 16'h0000);
      flush();

      // R8: saturation at 255
      c_minw = 8'd255; set_cfg();
      idle(3, 16'h0000);
      flush();
      s0 = short_seen;
      pulse15(300, 1'b1);
      flush();
      check_cnt("R8 300-sample pulse not short", short_seen - s0, 0);
      s0 = short_seen;
      pulse15(254, 1'b1);
      flush();
      check_cnt("R8 254-sample pulse short", short_seen - s0, 1);
      s0 = short_seen;
      pulse15(255, 1'b1);
      flush();
      check_cnt("R8 255-sample pulse not short", short_seen - s0, 0);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d actual=running expected=done", cyc);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule